// File: doc/BRIEF.md
# CAN Receive Bit Sampler with Hard Resynchronization

This block turns an oversampled CAN receive line into one sampled bit value per nominal bit time. The line first passes through a flop synchronizer. While idle, the block watches for the bus to turn dominant (low) and treats that clock cycle as the timing reference of the first bit. From then on it takes one sample per bit at a fixed offset into the bit and presents it together with a single-cycle strobe and the index of that bit. Stuff bits are not removed here; every nominal bit time yields a strobe.

Each recessive-to-dominant transition seen while bits are being collected moves the timing reference to that edge. The next bit, whose index equals the number of bits already sampled, is then sampled a full sample offset after the edge. The bit width and the sample offset are given in clock cycles and are held constant for the duration of a frame. A downstream frame decoder pulses a frame-done input at the end of a frame to put the block back into idle with its bit count cleared.

Top module: `can_bit_sampler`

## Requirements
- R1: Out of the active-low asynchronous reset the block is idle, `bit_valid_o` is 0, `bit_idx_o` is 0 and `bit_o` is 1.
- R2: `rx_i` passes through SYNC_STAGES flops (default 2) before any use, so that a level on `rx_i` can affect the logic only after those clock edges have passed.
- R3: While idle, no strobe is produced as long as the synchronized line stays recessive (1).
- R4: When the synchronized line first shows 0 in idle in clock cycle t, bit 0 is sampled in cycle t + `sample_off_i`. With default parameters, `bit_valid_o` is high for the one cycle after the rising edge that lies `sample_off_i` + 2 edges after the edge at which `rx_i` is first registered low.
- R5: Without an intervening falling edge, bit n+1 is sampled exactly `bit_width_i` clock cycles after bit n.
- R6: A 1-to-0 transition of the synchronized line in cycle e while collecting bits re-anchors timing: the not yet sampled bit with index equal to the current count is sampled in cycle e + `sample_off_i`.
- R7: `bit_valid_o` is a one-cycle strobe. While it is high, `bit_o` holds the synchronized line value from the sampling cycle; `bit_o` holds its value between strobes.
- R8: `bit_idx_o` is 0 for the first strobe after idle and increases by exactly 1 (modulo 2^IDX_W) on each further strobe, stuff bits included.
- R9: With `frame_done_i` high in a cycle, no strobe results from that cycle, and after the next clock edge the block is idle with its bit count at 0. The next frame starts again at index 0.
- R10: Any `sample_off_i` from 0 to `bit_width_i` - 1 is supported, including both ends of that range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous CAN receive line, 0 = dominant |
| bit_width_i | input | CNT_W | Clock cycles per nominal bit |
| sample_off_i | input | CNT_W | Sample position in clock cycles from bit start, less than bit_width_i |
| frame_done_i | input | 1 | Ends the frame and returns the block to idle |
| bit_o | output | 1 | Most recently sampled bit value |
| bit_valid_o | output | 1 | One-cycle strobe marking a new sampled bit |
| bit_idx_o | output | IDX_W | Index of the bit on bit_o within the frame |

## Verification
The bench builds the block with CNT_W = 8 and IDX_W = 8 and the default two synchronizer stages. With 8-bit timing fields it can draw bit widths from 2 to 20 clocks and every legal offset within them, so both ends of the offset range and the narrowest bit are reached in a few thousand cycles. Frames of up to about 70 bits, tail included, keep the 8-bit index from wrapping, so each strobe index is compared exactly. Bit lengths jittered by one clock move line edges both before and after the sample point, which exercises re-anchoring from both sides.

// File: rtl/can_sampler_pkg.sv
package can_sampler_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } samp_state_e;
endpackage

// File: rtl/can_line_sync.sv
module can_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic fall_o
);
  logic [STAGES:0] chain;
  logic            prev_q;

  assign chain[0] = d_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic stage_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= RST_VAL;
      else         stage_q <= chain[g];
    end
    assign chain[g+1] = stage_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= chain[STAGES];
  end

  assign q_o    = chain[STAGES];
  assign fall_o = prev_q & ~chain[STAGES];
endmodule

// File: rtl/can_phase_timer.sv
module can_phase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             anchor_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] off_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] ph_q;
  logic [CNT_W-1:0] ph_eff;
  logic [CNT_W-1:0] last_ph;

  // anchor puts the current cycle at phase 0 of the bit
  assign ph_eff  = anchor_i ? '0 : ph_q;
  assign last_ph = width_i - 1'b1;
  assign hit_o   = run_i && (ph_eff == off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ph_q <= '0;
    else if (!run_i)            ph_q <= '0;
    else if (ph_eff >= last_ph) ph_q <= '0;
    else                        ph_q <= ph_eff + 1'b1;
  end
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
  import can_sampler_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int IDX_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic [CNT_W-1:0] bit_width_i,
  input  logic [CNT_W-1:0] sample_off_i,
  input  logic             frame_done_i,
  output logic             bit_o,
  output logic             bit_valid_o,
  output logic [IDX_W-1:0] bit_idx_o
);
  samp_state_e      state_q;
  logic             rx_s;
  logic             fall;
  logic             run_q;
  logic             start;
  logic             anchor;
  logic             run_now;
  logic             hit;
  logic [IDX_W-1:0] cnt_q;
  logic             valid_q;
  logic             bit_q;
  logic [IDX_W-1:0] idx_q;

  can_line_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s),
    .fall_o(fall)
  );

  assign run_q   = (state_q == ST_RUN);
  assign start   = !run_q && !rx_s;
  assign anchor  = start || (run_q && fall);
  assign run_now = !frame_done_i && (run_q || start);

  can_phase_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_now),
    .anchor_i(anchor),
    .width_i (bit_width_i),
    .off_i   (sample_off_i),
    .hit_o   (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           state_q <= ST_IDLE;
    else if (frame_done_i) state_q <= ST_IDLE;
    else if (start)        state_q <= ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (frame_done_i) cnt_q <= '0;
    else if (hit)          cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      bit_q   <= 1'b1;
      idx_q   <= '0;
    end else begin
      valid_q <= hit;
      if (hit) begin
        bit_q <= rx_s;
        idx_q <= cnt_q;
      end
    end
  end

  assign bit_o       = bit_q;
  assign bit_valid_o = valid_q;
  assign bit_idx_o   = idx_q;
endmodule

// File: rtl/can_sampler_chk.sv
module can_sampler_chk #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_done_i,
  input logic [CNT_W-1:0] bit_width_i,
  input logic [CNT_W-1:0] sample_off_i,
  input logic             bit_valid_o,
  input logic [IDX_W-1:0] bit_idx_o,
  input logic             run_i,
  input logic             rx_s_i,
  input logic             fall_i,
  input logic [IDX_W-1:0] cnt_i
);
  logic             seen_q;
  logic             edge_q;
  logic [IDX_W-1:0] last_idx_q;
  logic [CNT_W:0]   gap_q;
  logic [CNT_W:0]   since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      edge_q     <= 1'b0;
      last_idx_q <= '0;
      gap_q      <= '0;
      since_q    <= '0;
    end else begin
      if (frame_done_i)     seen_q <= 1'b0;
      else if (bit_valid_o) seen_q <= 1'b1;
      if (frame_done_i)     edge_q <= 1'b0;
      else if (fall_i)      edge_q <= 1'b1;
      else if (bit_valid_o) edge_q <= 1'b0;
      if (bit_valid_o) last_idx_q <= bit_idx_o;
      if (bit_valid_o)    gap_q <= {{CNT_W{1'b0}}, 1'b1};
      else if (~&gap_q)   gap_q <= gap_q + 1'b1;
      if (fall_i)         since_q <= {{CNT_W{1'b0}}, 1'b1};
      else if (~&since_q) since_q <= since_q + 1'b1;
      if (bit_valid_o && seen_q) begin
        AST_IDX_STEP: assert (bit_idx_o == last_idx_q + 1'b1) // R8
          else $error("index did not advance by one");
      end
    end
  end

  AST_FIRST_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && !seen_q) |-> (bit_idx_o == '0)); // R8

  AST_SINGLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && sample_off_i != '0) |=> !bit_valid_o); // R7

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |=> (!bit_valid_o && !run_i && cnt_i == '0)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && rx_s_i) |=> !bit_valid_o); // R3

  AST_BIT_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && seen_q && !edge_q) |-> (gap_q == {1'b0, bit_width_i})); // R5

  AST_EDGE_ANCHOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && edge_q) |-> (since_q == {1'b0, sample_off_i} + 1'b1)); // R6
endmodule

bind can_bit_sampler can_sampler_chk #(
  .CNT_W(CNT_W),
  .IDX_W(IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_done_i(frame_done_i),
  .bit_width_i (bit_width_i),
  .sample_off_i(sample_off_i),
  .bit_valid_o (bit_valid_o),
  .bit_idx_o   (bit_idx_o),
  .run_i       (run_q),
  .rx_s_i      (rx_s),
  .fall_i      (fall),
  .cnt_i       (cnt_q)
);

// File: tb/tb_can_bit_sampler.sv
module tb_can_bit_sampler;
  localparam int CNT_W = 8;
  localparam int IDX_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             rx_i;
  logic [CNT_W-1:0] bit_width_i;
  logic [CNT_W-1:0] sample_off_i;
  logic             frame_done_i;
  logic             bit_o;
  logic             bit_valid_o;
  logic [IDX_W-1:0] bit_idx_o;

  always #5 clk_i = ~clk_i;

  can_bit_sampler #(.CNT_W(CNT_W), .IDX_W(IDX_W), .SYNC_STAGES(2)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i),
    .bit_width_i(bit_width_i), .sample_off_i(sample_off_i),
    .frame_done_i(frame_done_i), .bit_o(bit_o),
    .bit_valid_o(bit_valid_o), .bit_idx_o(bit_idx_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic m_s1 = 1'b1, m_s2 = 1'b1, m_prev = 1'b1;
  bit   m_active = 0;
  bit   m_edge = 0;
  int   m_cnt = 0, at = 0, an = 0, t = 0;
  int   bw = 10, off = 7;
  bit   exp_v = 0;
  logic exp_b = 1'b1;
  logic [IDX_W-1:0] exp_i = '0;
  string exp_tag = "R3";

  function automatic string cfg_tag(string base);
    if (off == 0 || off == bw - 1) return {base, " R10"};
    return base;
  endfunction

  task automatic step(input logic rx, input logic fd);
    bit hit;
    @(negedge clk_i);
    n_chk++;
    if (bit_valid_o !== exp_v) begin
      n_fail++;
      $display("FAIL %s valid got %0b exp %0b at t=%0d", exp_tag, bit_valid_o, exp_v, t);
    end
    if (exp_v) begin
      n_chk++;
      if (bit_o !== exp_b) begin
        n_fail++;
        $display("FAIL R7 bit got %0b exp %0b", bit_o, exp_b);
      end
      n_chk++;
      if (bit_idx_o !== exp_i) begin
        n_fail++;
        $display("FAIL R8 idx got %0d exp %0d", bit_idx_o, exp_i);
      end
    end
    rx_i = rx;
    frame_done_i = fd;
    bit_width_i = CNT_W'(bw);
    sample_off_i = CNT_W'(off);
    hit = 0;
    if (fd) begin
      m_active = 0;
      m_cnt = 0;
      m_edge = 0;
    end else begin
      if (!m_active && !m_s2) begin
        m_active = 1; at = t; an = 0; m_edge = 0;
      end else if (m_active && m_prev && !m_s2) begin
        at = t; an = m_cnt; m_edge = 1;
      end
      if (m_active && t == at + bw * (m_cnt - an) + off) begin
        hit = 1;
        exp_b = m_s2;
        exp_i = IDX_W'(m_cnt);
        m_cnt++;
      end
    end
    exp_v = hit;
    if (hit) begin
      if (exp_i == 0)  exp_tag = cfg_tag("R2/R4");
      else if (m_edge) exp_tag = cfg_tag("R6");
      else             exp_tag = cfg_tag("R5");
      m_edge = 0;
    end else if (fd)       exp_tag = "R9";
    else if (!m_active)    exp_tag = "R3";
    else                   exp_tag = cfg_tag("R5");
    t++;
    m_prev = m_s2;
    m_s2 = m_s1;
    m_s1 = rx;
  endtask

  task automatic end_frame();
    for (int k = 0; k < bw * 10; k++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
  endtask

  task automatic send_frame(input int nb, input bit jit);
    for (int b = 0; b < nb; b++) begin
      logic v;
      int len;
      v = (b == 0) ? 1'b0 : logic'($urandom_range(0, 1));
      len = bw;
      if (jit && bw > 3) len = bw + $urandom_range(0, 2) - 1;
      for (int k = 0; k < len; k++) step(v, 1'b0);
    end
    end_frame();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0;
    rx_i = 1'b1;
    frame_done_i = 1'b0;
    bit_width_i = CNT_W'(bw);
    sample_off_i = CNT_W'(off);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    n_chk++;
    if (bit_valid_o !== 1'b0 || bit_idx_o !== '0 || bit_o !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset got v=%0b i=%0d b=%0b exp v=0 i=0 b=1",
               bit_valid_o, bit_idx_o, bit_o);
    end
    rst_ni = 1'b1;

    // R3 long recessive idle
    for (int k = 0; k < 60; k++) step(1'b1, 1'b0);

    // R4 R5 R6 directed, no jitter
    bw = 10; off = 7;
    send_frame(20, 0);
    // R10 offset at both ends
    bw = 8; off = 0;
    send_frame(25, 1);
    bw = 9; off = 8;
    send_frame(25, 1);
    bw = 2; off = 1;
    send_frame(30, 0);

    // R9 frame_done while line dominant, then restart from idle
    bw = 6; off = 3;
    for (int k = 0; k < bw * 3; k++) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    for (int k = 0; k < bw * 3; k++) step(1'b0, 1'b0);
    for (int k = 0; k < bw * 2; k++) step(1'b1, 1'b0);
    end_frame();

    // random configurations and jittered frames
    for (int f = 0; f < 25; f++) begin
      bw = $urandom_range(3, 20);
      off = $urandom_range(0, bw - 1);
      send_frame($urandom_range(10, 60), 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule